// File: doc/BRIEF.md
# System Sleep State Controller

This block follows the power state of a small PC-style platform. It covers three processor idle states (C0 running, C1 halted, C2 clock-stopped), three sleep states (S1, S3, S4), soft-off (S5) and mechanical-off (G3). Software strobes move it between idle states and into sleep. Break events bring the processor back to C0. Enabled wake events, or a power-button press, bring the platform out of sleep. A power failure sends the block to G3 from any state.

The power button is an active-low pin. It passes through a synchronizer before any logic uses it. A press while running raises a sleep-request interrupt flag for software. A press while asleep is a wake event. If the button is held for longer than a programmable number of slow always-on ticks, the block forces soft-off. After that forced entry, only the button can wake the platform.

The after-power-loss option is an input held by always-on storage outside the block. When power returns, it chooses between rebooting into C0 and staying in S5. The block drives the main-plane control, the supply-on command, stop-clock and CPU-sleep. A wake-status register records which sources caused the last wake, and software clears its bits by writing one to them.

Top module: `sleep_state_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the state is G3, slp_main_n is 0, supply_on_n is 1, stpclk and cpuslp are 0, sleep_irq is 0 and wake_sts is 0.
- R2: In G3, once pwr_good is 1 and pwr_fail is 0, the next state is C0 when after_loss_off is 0 and S5 when it is 1. Wake inputs and the button have no effect in G3.
- R3: In C0, the inputs are taken in this order of priority. First, slp_en with a valid slp_typ selects the sleep state: 1 gives S1, 3 gives S3, 4 gives S4 and 5 gives S5. Any other slp_typ value leaves the state at C0. Second, lvl2_rd gives C2. Third, halt_req gives C1.
- R4: In C1, brk_evt gives C0, and otherwise stpclk_req gives C2. brk_evt wins when both are present.
- R5: In C2, brk_evt gives C0. If C2 was entered from C1, stpclk_req going to 0 gives C1. If C2 was entered from C0, stpclk_req is ignored. brk_evt wins over the return to C1.
- R6: A button press (the synchronized falling edge) in C0, C1 or C2 sets sleep_irq and leaves the state unchanged. sleep_irq stays set until irq_clr is 1.
- R7: In S1, S3, S4 or S5, the next state is C0 when there is a button press or an asserted wake input whose enable is set. The enable bits are wake_en[0] for the ring indicator, wake_en[1] for LAN and wake_en[2] for RTC. In C0, C1 and C2, wake inputs have no effect.
- R8: When the synchronized button has been low across more than OVR_TICKS tick pulses, the state goes to S5 from any state except G3. After exactly OVR_TICKS tick pulses, the state does not change.
- R9: After an override entry into S5, only a button press wakes the platform. The other sources are ignored and are not recorded. This lasts until the next wake.
- R10: pwr_fail has the highest priority. It gives G3 on the next clock from any state.
- R11: slp_main_n is 0 in S3, S4, S5 and G3 and is 1 otherwise. supply_on_n is 0 in C0, C1, C2 and S1 and is 1 otherwise.
- R12: stpclk is 1 in C2 and S1. cpuslp is 1 only in S1 with cpuslp_en set.
- R13: wake_sts has these bits: bit0 button, bit1 ring indicator, bit2 LAN, bit3 RTC. On a wake, every source that caused it sets its bit. A bit stays set until a one is written to it on wsts_clr. A set in the same cycle as a clear wins.
- R14: state_o reports the current state with these codes: C0=0, C1=1, C2=2, S1=3, S3=4, S4=5, S5=6, G3=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow always-on tick pulse for the hold timer |
| pwrbtn_n | input | 1 | Power button, low when pressed, asynchronous |
| halt_req | input | 1 | Processor halt strobe |
| lvl2_rd | input | 1 | Level-2 idle read strobe |
| slp_en | input | 1 | Sleep-enable strobe |
| slp_typ | input | 3 | Sleep type selector |
| brk_evt | input | 1 | Enabled break event |
| stpclk_req | input | 1 | Stop-clock request level used from C1 |
| wake_ri | input | 1 | Ring indicator wake |
| wake_lan | input | 1 | LAN wake |
| wake_rtc | input | 1 | RTC alarm wake |
| wake_en | input | 3 | Wake enables {rtc, lan, ri} |
| pwr_good | input | 1 | Supply is valid |
| pwr_fail | input | 1 | Supply failure |
| after_loss_off | input | 1 | Stay in S5 after power returns |
| cpuslp_en | input | 1 | Allow CPU-sleep in S1 |
| irq_clr | input | 1 | Clear the sleep-request flag |
| wsts_clr | input | 4 | Write-one-to-clear for wake_sts |
| slp_main_n | output | 1 | Main-plane control, low means off |
| supply_on_n | output | 1 | Supply-on command, low means on |
| stpclk | output | 1 | Stop-clock to the processor |
| cpuslp | output | 1 | CPU-sleep to the processor |
| sleep_irq | output | 1 | Sleep-request interrupt flag |
| state_o | output | 3 | Current state code |
| wake_sts | output | 4 | Latched wake sources |

## Verification
The case that matters most is two of the block's functions landing in the same cycle. The bench holds C2, entered from C1, and then drops stpclk_req in the very cycle that brk_evt arrives. The result must be C0, not C1. It also sets a wake-status bit in the same cycle that software writes one to clear it, and expects the bit to stay set. In a third case, pwr_fail arrives together with a break event in C1, and the state must go to G3. Each result is compared at the ports on the clock that follows. The sleep types are swept over all eight slp_typ codes, and expected states and output levels are computed in the bench.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    PS_C0 = 3'd0,
    PS_C1 = 3'd1,
    PS_C2 = 3'd2,
    PS_S1 = 3'd3,
    PS_S3 = 3'd4,
    PS_S4 = 3'd5,
    PS_S5 = 3'd6,
    PS_G3 = 3'd7
  } pstate_t;

  localparam int WAKE_SRCS = 4;  // button, ring, lan, rtc

  function automatic logic is_running(pstate_t s);
    return (s == PS_C0) || (s == PS_C1) || (s == PS_C2);
  endfunction

  function automatic logic plane_off(pstate_t s);
    return (s == PS_S3) || (s == PS_S4) || (s == PS_S5) || (s == PS_G3);
  endfunction

  // Maps the sleep type code to its target; PS_C0 marks an unused code.
  function automatic pstate_t sleep_target(logic [2:0] typ);
    case (typ)
      3'd1:    return PS_S1;
      3'd3:    return PS_S3;
      3'd4:    return PS_S4;
      3'd5:    return PS_S5;
      default: return PS_C0;
    endcase
  endfunction

endpackage

// File: rtl/pwr_btn_guard.sv
module pwr_btn_guard #(
  parameter int OVR_TICKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_n_raw,
  output logic btn_press,
  output logic ovr_fire
);
  localparam int CW = $clog2(OVR_TICKS + 2);
  localparam logic [CW-1:0] LIMIT = CW'(OVR_TICKS);

  // Synchronizer stages plus one delay stage for edge detection.
  logic [SYNC_STAGES:0] shr;
  logic                 btn_s, btn_d;
  logic [CW-1:0]        held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr <= '1;
    else        shr <= {shr[SYNC_STAGES-1:0], btn_n_raw};
  end

  assign btn_s     = shr[SYNC_STAGES-1];
  assign btn_d     = shr[SYNC_STAGES];
  assign btn_press = btn_d & ~btn_s;

  // Counts tick pulses while held; saturates one past the limit so it fires once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    held <= '0;
    else if (btn_s)                held <= '0;
    else if (tick && held <= LIMIT) held <= held + 1'b1;
  end

  assign ovr_fire = tick & ~btn_s & (held == LIMIT);

endmodule

// File: rtl/pwr_wake_status.sv
module pwr_wake_status #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] sts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_req,
  input  logic                 lvl2_rd,
  input  logic                 slp_en,
  input  logic [2:0]           slp_typ,
  input  logic                 brk_evt,
  input  logic                 stpclk_req,
  input  logic                 btn_press,
  input  logic                 ovr_fire,
  input  logic [WAKE_SRCS-1:0] wake_req,
  input  logic                 pwr_good,
  input  logic                 pwr_fail,
  input  logic                 after_loss_off,
  input  logic                 irq_clr,
  output pstate_t              st,
  output logic                 ovr_lock,
  output logic                 wake_take,
  output logic [WAKE_SRCS-1:0] wake_set,
  output logic                 sleep_irq
);
  pstate_t               nxt, tgt;
  logic                  from_c1, nxt_from_c1, nxt_lock;
  logic [WAKE_SRCS-1:0]  hits;

  always_comb begin
    hits = wake_req;
    if (ovr_lock) hits[WAKE_SRCS-1:1] = '0;
    tgt         = sleep_target(slp_typ);
    nxt         = st;
    nxt_lock    = ovr_lock;
    nxt_from_c1 = from_c1;
    wake_take   = 1'b0;
    if (pwr_fail) begin
      nxt      = PS_G3;
      nxt_lock = 1'b0;
    end else if (st == PS_G3) begin
      if (pwr_good) nxt = after_loss_off ? PS_S5 : PS_C0;
    end else if (ovr_fire) begin
      nxt      = PS_S5;
      nxt_lock = 1'b1;
    end else begin
      case (st)
        PS_C0: begin
          if (slp_en && tgt != PS_C0) nxt = tgt;
          else if (lvl2_rd) begin
            nxt         = PS_C2;
            nxt_from_c1 = 1'b0;
          end else if (halt_req) nxt = PS_C1;
        end
        PS_C1: begin
          if (brk_evt) nxt = PS_C0;
          else if (stpclk_req) begin
            nxt         = PS_C2;
            nxt_from_c1 = 1'b1;
          end
        end
        PS_C2: begin
          if (brk_evt) nxt = PS_C0;
          else if (from_c1 && !stpclk_req) nxt = PS_C1;
        end
        default: begin
          if (|hits) begin
            nxt       = PS_C0;
            nxt_lock  = 1'b0;
            wake_take = 1'b1;
          end
        end
      endcase
    end
  end

  assign wake_set = wake_take ? hits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_G3;
      ovr_lock  <= 1'b0;
      from_c1   <= 1'b0;
      sleep_irq <= 1'b0;
    end else begin
      st        <= nxt;
      ovr_lock  <= nxt_lock;
      from_c1   <= nxt_from_c1;
      sleep_irq <= (sleep_irq & ~irq_clr) | (btn_press & is_running(st));
    end
  end

endmodule

// File: rtl/sleep_state_ctrl.sv
module sleep_state_ctrl
  import pwr_pkg::*;
#(
  parameter int OVR_TICKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pwrbtn_n,
  input  logic       halt_req,
  input  logic       lvl2_rd,
  input  logic       slp_en,
  input  logic [2:0] slp_typ,
  input  logic       brk_evt,
  input  logic       stpclk_req,
  input  logic       wake_ri,
  input  logic       wake_lan,
  input  logic       wake_rtc,
  input  logic [2:0] wake_en,
  input  logic       pwr_good,
  input  logic       pwr_fail,
  input  logic       after_loss_off,
  input  logic       cpuslp_en,
  input  logic       irq_clr,
  input  logic [3:0] wsts_clr,
  output logic       slp_main_n,
  output logic       supply_on_n,
  output logic       stpclk,
  output logic       cpuslp,
  output logic       sleep_irq,
  output logic [2:0] state_o,
  output logic [3:0] wake_sts
);
  // Named internal events, also used by the bound checker.
  logic                 btn_press;
  logic                 ovr_fire;
  logic                 ovr_lock;
  logic                 wake_take;
  logic [WAKE_SRCS-1:0] wake_req;
  logic [WAKE_SRCS-1:0] wake_set;
  pstate_t              st;

  assign wake_req = {wake_rtc & wake_en[2], wake_lan & wake_en[1],
                     wake_ri & wake_en[0], btn_press};

  pwr_btn_guard #(.OVR_TICKS(OVR_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .btn_n_raw (pwrbtn_n),
    .btn_press (btn_press),
    .ovr_fire  (ovr_fire)
  );

  pwr_state_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .halt_req       (halt_req),
    .lvl2_rd        (lvl2_rd),
    .slp_en         (slp_en),
    .slp_typ        (slp_typ),
    .brk_evt        (brk_evt),
    .stpclk_req     (stpclk_req),
    .btn_press      (btn_press),
    .ovr_fire       (ovr_fire),
    .wake_req       (wake_req),
    .pwr_good       (pwr_good),
    .pwr_fail       (pwr_fail),
    .after_loss_off (after_loss_off),
    .irq_clr        (irq_clr),
    .st             (st),
    .ovr_lock       (ovr_lock),
    .wake_take      (wake_take),
    .wake_set       (wake_set),
    .sleep_irq      (sleep_irq)
  );

  pwr_wake_status #(.W(WAKE_SRCS)) u_wsts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (wake_set),
    .clr_vec (wsts_clr),
    .sts     (wake_sts)
  );

  assign state_o     = st;
  assign slp_main_n  = ~plane_off(st);
  assign supply_on_n = plane_off(st);
  assign stpclk      = (st == PS_C2) || (st == PS_S1);
  assign cpuslp      = (st == PS_S1) && cpuslp_en;

endmodule

// File: rtl/sleep_state_ctrl_chk.sv
module sleep_state_ctrl_chk
  import pwr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_fail,
  input logic [2:0] state_o,
  input logic       supply_on_n,
  input logic       stpclk,
  input logic       cpuslp,
  input logic [3:0] wake_sts,
  input logic [3:0] wsts_clr,
  input logic       ovr_fire,
  input logic       ovr_lock,
  input logic       btn_press,
  input logic       wake_take
);
  // R10
  fail_to_g3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> state_o == PS_G3);

  // R8
  override_s5_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_fire && !pwr_fail && state_o != PS_G3) |=> state_o == PS_S5);

  // R9
  locked_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_lock && state_o == PS_S5 && !btn_press && !pwr_fail && !ovr_fire)
      |=> state_o == PS_S5);

  // R7
  wake_to_c0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_take |=> state_o == PS_C0);

  // R11
  supply_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_on_n) |-> state_o == PS_C0);

  // R12
  cpuslp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpuslp |-> stpclk);

  // R13
  wsts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_take && wsts_clr == 4'd0) |=> $stable(wake_sts));

endmodule

bind sleep_state_ctrl sleep_state_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_fail    (pwr_fail),
  .state_o     (state_o),
  .supply_on_n (supply_on_n),
  .stpclk      (stpclk),
  .cpuslp      (cpuslp),
  .wake_sts    (wake_sts),
  .wsts_clr    (wsts_clr),
  .ovr_fire    (ovr_fire),
  .ovr_lock    (ovr_lock),
  .btn_press   (btn_press),
  .wake_take   (wake_take)
);

// File: tb/sim_sleep_state_ctrl.sv
module sim_sleep_state_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, pwrbtn_n = 1, halt_req = 0, lvl2_rd = 0, slp_en = 0;
  logic [2:0] slp_typ = 0;
  logic brk_evt = 0, stpclk_req = 0, wake_ri = 0, wake_lan = 0, wake_rtc = 0;
  logic [2:0] wake_en = 0;
  logic pwr_good = 0, pwr_fail = 0, after_loss_off = 0, cpuslp_en = 0, irq_clr = 0;
  logic [3:0] wsts_clr = 0;
  logic slp_main_n, supply_on_n, stpclk, cpuslp, sleep_irq;
  logic [2:0] state_o;
  logic [3:0] wake_sts;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam int TICKS = 4;
  localparam int C0 = 0, C1 = 1, C2 = 2, S1 = 3, S3 = 4, S4 = 5, S5 = 6, G3 = 7;

  always #5 clk = ~clk;

  sleep_state_ctrl #(.OVR_TICKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwrbtn_n(pwrbtn_n),
    .halt_req(halt_req), .lvl2_rd(lvl2_rd), .slp_en(slp_en), .slp_typ(slp_typ),
    .brk_evt(brk_evt), .stpclk_req(stpclk_req), .wake_ri(wake_ri),
    .wake_lan(wake_lan), .wake_rtc(wake_rtc), .wake_en(wake_en),
    .pwr_good(pwr_good), .pwr_fail(pwr_fail), .after_loss_off(after_loss_off),
    .cpuslp_en(cpuslp_en), .irq_clr(irq_clr), .wsts_clr(wsts_clr),
    .slp_main_n(slp_main_n), .supply_on_n(supply_on_n), .stpclk(stpclk),
    .cpuslp(cpuslp), .sleep_irq(sleep_irq), .state_o(state_o), .wake_sts(wake_sts)
  );

  function automatic int exp_sleep(int t);
    case (t)
      1: return S1;
      3: return S3;
      4: return S4;
      5: return S5;
      default: return C0;
    endcase
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    check("R1 state", state_o, G3);
    check("R1 slp_main_n", slp_main_n, 0);
    check("R1 supply_on_n", supply_on_n, 1);
    check("R1 stpclk", stpclk, 0);
    check("R1 wake_sts", wake_sts, 0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 after release", state_o, G3);
    check("R1 sleep_irq", sleep_irq, 0);

    // R2 wake ignored in G3, then reboot path
    wake_en = 3'b111; wake_ri = 1;
    cyc(3);
    check("R2 G3 ignores wake", state_o, G3);
    check("R2 no wake_sts", wake_sts, 0);
    wake_ri = 0; pwr_good = 1; after_loss_off = 0;
    cyc(1);
    check("R2 reboot to C0", state_o, C0);
    check("R11 supply on in C0", supply_on_n, 0);
    check("R11 main on in C0", slp_main_n, 1);

    // R3 sweep of every sleep type code
    cpuslp_en = 1;
    for (int t = 0; t < 8; t++) begin
      slp_typ = 3'(t); slp_en = 1;
      cyc(1);
      slp_en = 0;
      check("R3/R14 sleep type", state_o, exp_sleep(t));
      check("R11 main plane", slp_main_n, (t >= 3 && t <= 5) ? 0 : 1);
      check("R11 supply", supply_on_n, (t >= 3 && t <= 5) ? 1 : 0);
      check("R12 stpclk", stpclk, (t == 1) ? 1 : 0);
      check("R12 cpuslp", cpuslp, (t == 1) ? 1 : 0);
      if (exp_sleep(t) != C0) begin
        wake_rtc = 1;
        cyc(1);
        wake_rtc = 0;
        check("R7 rtc wake", state_o, C0);
        check("R13 rtc bit", wake_sts, 8);
        wsts_clr = 4'b1000;
        cyc(1);
        wsts_clr = 0;
        check("R13 clear", wake_sts, 0);
      end
    end

    // R12 S1 without cpu-sleep permission
    cpuslp_en = 0; slp_typ = 3'd1; slp_en = 1;
    cyc(1);
    slp_en = 0;
    check("R12 S1 stpclk", stpclk, 1);
    check("R12 S1 cpuslp off", cpuslp, 0);
    wake_ri = 1;
    cyc(1);
    wake_ri = 0;
    check("R7 ri wake", state_o, C0);
    check("R13 ri bit", wake_sts, 2);
    wsts_clr = 4'hF; cyc(1); wsts_clr = 0;

    // R3 priority: all three strobes together
    slp_typ = 3'd3; slp_en = 1; lvl2_rd = 1; halt_req = 1;
    cyc(1);
    slp_en = 0;
    check("R3 sleep wins", state_o, S3);
    wake_lan = 1; cyc(1); wake_lan = 0;
    wsts_clr = 4'hF; cyc(1); wsts_clr = 0;
    cyc(1);
    lvl2_rd = 0; halt_req = 0;
    // previous cycle had lvl2+halt in C0 -> C2
    check("R3 lvl2 over halt", state_o, C2);
    check("R12 stpclk in C2", stpclk, 1);
    brk_evt = 1; cyc(1); brk_evt = 0;
    check("R5 break from C2", state_o, C0);

    // R4 / R5 idle sequencing
    halt_req = 1; cyc(1); halt_req = 0;
    check("R3 halt to C1", state_o, C1);
    brk_evt = 1; stpclk_req = 1; cyc(1); brk_evt = 0; stpclk_req = 0;
    check("R4 break wins in C1", state_o, C0);
    halt_req = 1; cyc(1); halt_req = 0;
    stpclk_req = 1; cyc(1);
    check("R4 stpclk to C2", state_o, C2);
    cyc(2);
    check("R5 hold C2", state_o, C2);
    stpclk_req = 0; cyc(1);
    check("R5 back to C1", state_o, C1);
    stpclk_req = 1; cyc(1);
    check("R4 C2 again", state_o, C2);
    stpclk_req = 0; brk_evt = 1; cyc(1); brk_evt = 0;
    check("R5 break beats release", state_o, C0);
    lvl2_rd = 1; cyc(1); lvl2_rd = 0;
    cyc(3);
    check("R5 C2 from C0 ignores release", state_o, C2);
    brk_evt = 1; cyc(1); brk_evt = 0;

    // R6 press while running
    pwrbtn_n = 0; cyc(4);
    check("R6 irq set", sleep_irq, 1);
    check("R6 state kept", state_o, C0);
    pwrbtn_n = 1; cyc(3);
    check("R6 irq held", sleep_irq, 1);
    irq_clr = 1; cyc(1); irq_clr = 0;
    check("R6 irq cleared", sleep_irq, 0);

    // R7 disabled source, running ignores wakes, button wake
    slp_typ = 3'd3; slp_en = 1; cyc(1); slp_en = 0;
    wake_en = 3'b101; wake_lan = 1; cyc(3);
    check("R7 disabled lan ignored", state_o, S3);
    wake_en = 3'b111; cyc(1); wake_lan = 0;
    check("R7 lan wake", state_o, C0);
    check("R13 lan bit", wake_sts, 4);
    wsts_clr = 4'hF; cyc(1); wsts_clr = 0;
    wake_ri = 1; cyc(2); wake_ri = 0;
    check("R7 running ignores wake", wake_sts, 0);
    check("R7 running state", state_o, C0);
    slp_typ = 3'd4; slp_en = 1; cyc(1); slp_en = 0;
    pwrbtn_n = 0; cyc(4);
    check("R7 button wake", state_o, C0);
    check("R13 button bit", wake_sts, 1);
    check("R6 no irq for wake press", sleep_irq, 0);
    pwrbtn_n = 1; cyc(3);
    wsts_clr = 4'hF; cyc(1); wsts_clr = 0;

    // R8 override boundary
    pwrbtn_n = 0; cyc(3);
    for (int k = 0; k < TICKS; k++) begin
      tick = 1; cyc(1); tick = 0; cyc(1);
    end
    check("R8 exact limit no override", state_o, C0);
    tick = 1; cyc(1); tick = 0;
    check("R8 override to S5", state_o, S5);
    cyc(2);
    pwrbtn_n = 1; cyc(3);
    irq_clr = 1; cyc(1); irq_clr = 0;

    // R9 only button wakes after override
    wake_ri = 1; wake_rtc = 1; cyc(3);
    check("R9 ri/rtc masked", state_o, S5);
    check("R9 nothing recorded", wake_sts, 0);
    wake_rtc = 0;
    pwrbtn_n = 0; cyc(4);
    check("R9 button wakes", state_o, C0);
    check("R9 only button bit", wake_sts, 1);
    wake_ri = 0; pwrbtn_n = 1; cyc(3);
    wsts_clr = 4'hF; cyc(1); wsts_clr = 0;

    // R10 power fail with competing break, then stay-off return
    halt_req = 1; cyc(1); halt_req = 0;
    pwr_fail = 1; brk_evt = 1; cyc(1); brk_evt = 0;
    check("R10 fail to G3", state_o, G3);
    check("R11 G3 main off", slp_main_n, 0);
    after_loss_off = 1; pwr_fail = 0; cyc(1);
    check("R2 stay off in S5", state_o, S5);

    // R13 set in same cycle as clear
    wsts_clr = 4'b1000; wake_rtc = 1; cyc(1); wake_rtc = 0; wsts_clr = 0;
    check("R13 set beats clear", wake_sts, 8);
    check("R7 unlocked S5 rtc wake", state_o, C0);

    done = 1;
    summary();
  end
endmodule